// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers event pulses from five sources inside a peripheral chip (two timers, a time-of-day alarm, a serial port and an external flag line) and turns them into one active-low interrupt request. Each source pulse sets a sticky flag. A five-bit enable mask decides which flags may raise the request. The flags always latch, even when their source is masked off.

Software reaches the block through one 8-bit register location. A write changes the mask. Bit 7 of the written byte picks whether to set or to clear, and only the bit positions written as 1 are affected. A read returns the five flags together with a summary bit that is high when any enabled flag is pending. The read also empties all flags on the clock edge that ends it, which releases the request line. The read view is always visible on `rdata`, and only the read strobe has the clearing side effect.

Top module: `irq_ctrl_top`

## Requirements
- R1: A write with wdata[7]=1 sets every mask bit i (0..4) for which wdata[i]=1.
- R2: A write with wdata[7]=0 clears every mask bit i (0..4) for which wdata[i]=1.
- R3: A mask bit whose written data bit is 0 keeps its value in either mode, and wdata[6:5] have no effect on the mask.
- R4: An event pulse on ev_pulse[i] sets flag i on the next clock edge, whatever the state of mask bit i.
- R5: The read view places flags in rdata[4:0] in the order bit0 timer A, bit1 timer B, bit2 alarm, bit3 serial, bit4 external flag; rdata[6:5] read 0; rdata[7] is the summary bit.
- R6: The summary bit is 1 exactly when some flag and its mask bit are both 1, and irq_n is 0 exactly while the summary bit is 1.
- R7: A clock edge with rd_en=1 clears every flag that has no event in that cycle, so the summary bit drops and irq_n returns high.
- R8: An event pulse in the same cycle as a read strobe leaves its flag set after the clearing edge.
- R9: Reset (rst_n=0) clears all flags and all mask bits, giving rdata=0x00 and irq_n=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe: update the mask from wdata |
| rd_en | input | 1 | Read strobe: clear the flags at this edge |
| wdata | input | 8 | Write data: bit 7 selects set/clear, bits 4:0 select mask bits |
| rdata | output | 8 | Read view: summary bit, zeros, five flags |
| ev_pulse | input | 5 | One-cycle event pulses, one per source |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The mask update is driven with set-mode and clear-mode bytes that have several bits selected, with bytes that touch only bits 6:5, and with bytes that mix selected and unselected bits. These patterns separate an update that affects only the selected bits from one that overwrites the whole mask or that decodes the don't-care bits. Events are applied while their mask bits are off and while they are on. This shows that flags latch independently of the mask and that the mask gates only the request. Reads are issued both alone and together with events, which separates a plain clear from a clear that drops an event arriving in the same cycle. A deterministic pseudo-random run then mixes all of these.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int unsigned NSRC_DEF = 5;
    localparam int unsigned DW_DEF   = 8;
    localparam int unsigned MODE_DEF = 7;

    typedef enum int unsigned {
        SRC_TMR_A = 0,
        SRC_TMR_B = 1,
        SRC_ALARM = 2,
        SRC_SER   = 3,
        SRC_EXT   = 4
    } src_idx_e;
endpackage

// File: rtl/icu_mask_reg.sv
module icu_mask_reg #(
    parameter int unsigned NSRC     = icu_pkg::NSRC_DEF,
    parameter int unsigned DW       = icu_pkg::DW_DEF,
    parameter int unsigned MODE_BIT = icu_pkg::MODE_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
    } state_t;

    state_t          st_d, st_q;
    logic [NSRC-1:0] bit_nxt;
    logic            set_mode;
    logic            unused_dc;

    assign set_mode  = wdata[MODE_BIT];
    assign unused_dc = ^wdata[MODE_BIT-1:NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        assign bit_nxt[i] = (wr_en && wdata[i]) ? set_mode : st_q.mask[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.mask = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[MODE_BIT]) |=> ((mask_o & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[MODE_BIT]) |=> ((mask_o & $past(wdata[NSRC-1:0])) == '0));
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_o & ~($past(wdata[NSRC-1:0]) & {NSRC{$past(wr_en)}}))
               == ($past(mask_o) & ~($past(wdata[NSRC-1:0]) & {NSRC{$past(wr_en)}}))));
endmodule

// File: rtl/icu_flag_latch.sv
module icu_flag_latch #(
    parameter int unsigned NSRC = icu_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic            clr_i,
    output logic [NSRC-1:0] flags_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flags = '0;
        st_d.flags = st_d.flags | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    assert_flag_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((flags_o & $past(ev_i)) == $past(ev_i)));
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ev_i == '0) |=> (flags_o == '0));
    assert_keep_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ev_i != '0) |=> (flags_o == $past(ev_i)));
endmodule

// File: rtl/icu_status_view.sv
module icu_status_view #(
    parameter int unsigned NSRC   = icu_pkg::NSRC_DEF,
    parameter int unsigned DW     = icu_pkg::DW_DEF,
    parameter int unsigned IR_BIT = icu_pkg::MODE_DEF
) (
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [DW-1:0]   rdata_o,
    output logic            ir_o
);
    always_comb begin
        ir_o                  = |(flags_i & mask_i);
        rdata_o               = '0;
        rdata_o[NSRC-1:0]     = flags_i;
        rdata_o[IR_BIT]       = ir_o;
    end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
    parameter int unsigned NSRC     = icu_pkg::NSRC_DEF,
    parameter int unsigned DW       = icu_pkg::DW_DEF,
    parameter int unsigned MODE_BIT = icu_pkg::MODE_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] ev_pulse,
    output logic            irq_n
);
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] flags;
    logic            ir;

    icu_mask_reg #(.NSRC(NSRC), .DW(DW), .MODE_BIT(MODE_BIT)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .mask_o(mask)
    );

    icu_flag_latch #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_pulse), .clr_i(rd_en), .flags_o(flags)
    );

    icu_status_view #(.NSRC(NSRC), .DW(DW), .IR_BIT(MODE_BIT)) u_view (
        .flags_i(flags), .mask_i(mask), .rdata_o(rdata), .ir_o(ir)
    );

    assign irq_n = ~ir;

    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) == '0) |-> (irq_n && !rdata[MODE_BIT]));
    assert_irq_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) != '0) |-> (!irq_n && rdata[MODE_BIT]));
    assert_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[MODE_BIT-1:NSRC] == '0);
endmodule

// File: tb/tb_irq_ctrl_top.sv
`timescale 1ns/1ps
module tb_irq_ctrl_top;
    typedef struct {
        logic [7:0] rd;
        logic       irqn;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [4:0] ev_pulse = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    item_t expq[$];
    logic [4:0] m_mask = '0;
    logic [4:0] m_flags = '0;

    always #2.5 clk = ~clk;

    irq_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse), .irq_n(irq_n)
    );

    function automatic logic [7:0] view(input logic [4:0] f, input logic [4:0] m);
        return {|(f & m), 2'b00, f};
    endfunction

    task automatic cmp(input string req, input logic [7:0] rd_e, input logic irq_e);
        checks++;
        if (rdata !== rd_e || irq_n !== irq_e) begin
            errors++;
            $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                     req, rdata, irq_n, rd_e, irq_e);
        end
    endtask

    // Driver: apply one cycle of stimulus, update the model, queue the expectation.
    task automatic op(input logic w, input logic r, input logic [7:0] wd,
                      input logic [4:0] ev, input string req);
        item_t it;
        @(negedge clk);
        wr_en = w; rd_en = r; wdata = wd; ev_pulse = ev;
        #1;
        if (r) cmp({req, " read view"}, view(m_flags, m_mask), ~|(m_flags & m_mask));
        if (w) m_mask = wd[7] ? (m_mask | wd[4:0]) : (m_mask & ~wd[4:0]);
        m_flags = (r ? 5'b0 : m_flags) | ev;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0; ev_pulse = '0;
        it.rd = view(m_flags, m_mask);
        it.irqn = ~|(m_flags & m_mask);
        it.req = req;
        expq.push_back(it);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            item_t it;
            it = expq.pop_front();
            cmp(it.req, it.rd, it.irqn);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_mask = '0; m_flags = '0;
        #1;
        cmp("R9 reset", 8'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        #1;
        cmp("R9 reset", 8'h00, 1'b1);
        rst_n = 1'b1;
        op(1'b0, 1'b0, 8'h00, 5'b00001, "R4 latch while masked");
        op(1'b1, 1'b0, 8'h81, 5'b00000, "R1 set TA R6 request");
        op(1'b1, 1'b0, 8'h9E, 5'b00000, "R1 set others");
        op(1'b1, 1'b0, 8'h02, 5'b00000, "R2 clear TB");
        op(1'b0, 1'b0, 8'h00, 5'b00010, "R6 masked TB no extra");
        op(1'b1, 1'b0, 8'h60, 5'b00000, "R3 clear mode bits 6:5");
        op(1'b1, 1'b0, 8'hE0, 5'b00000, "R3 set mode bits 6:5");
        op(1'b0, 1'b0, 8'h00, 5'b11000, "R5 ext and serial positions");
        op(1'b0, 1'b1, 8'h00, 5'b00000, "R7 read clears");
        op(1'b0, 1'b0, 8'h00, 5'b00100, "R5 alarm position");
        op(1'b0, 1'b1, 8'h00, 5'b00010, "R8 event during read");
        op(1'b1, 1'b0, 8'h1F, 5'b00001, "R2 clear all R4 latch");
        op(1'b1, 1'b0, 8'h8A, 5'b00000, "R3 mixed bits R1");
        op(1'b0, 1'b1, 8'h00, 5'b00000, "R7 release");
        lf = 8'h5B;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            op(lf[0], lf[3] & lf[5], {lf[7:5], lf[6:2]}, lf[4:0] & {5{lf[1]}}, "R6 mixed run");
        end
        @(negedge clk);
        @(negedge clk);
        do_reset();
        op(1'b0, 1'b0, 8'h00, 5'b00000, "R9 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule